// File: doc/BRIEF.md
# Two-Stage Skewed-Operand Ripple Adder

This block adds two 4-bit numbers using two 2-bit ripple-carry halves with a register between them. A new addition can start on every clock. The work per stage is half of the full ripple path, so a stage is roughly four gate delays deep where an unsplit 4-bit ripple is about eight.

Operands arrive skewed. The lower two bits of both operands and the valid strobe come in one cycle. The upper two bits of the same addition come in the next cycle. The carry out of bit 1 is held in a register and becomes the carry into bit 2 one cycle later. The results leave in the same skewed form: the lower sum bits come out first, and the upper sum bits and the final carry come out one cycle after them. The block does not de-skew its inputs or its outputs; the stages around it handle that.

The arithmetic runs on every cycle, whether or not the strobe is set. Each valid flag only marks which output slots hold a real addition. Downstream logic is expected to read only the marked slots.

Top module: `stagger_add4`

## Requirements
- R1: A synchronous active-high reset (`rst` high at a rising edge) clears all five outputs to zero from that edge onward.
- R2: `out_sum_lo` after edge k equals the low 2 bits of `lo_a + lo_b` sampled at edge k.
- R3: The carry out of bit 1 (bit 2 of `lo_a + lo_b`) sampled at edge k is the carry into the upper half at edge k+1. So `out_sum_hi` after edge k+1 equals the low 2 bits of `hi_a + hi_b + carry`, with `hi_a`/`hi_b` sampled at edge k+1.
- R4: `out_carry` comes out in the same cycle as `out_sum_hi`, and it is bit 2 of the 3-bit sum described in R3.
- R5: `out_lo_valid` after edge k equals `in_valid` at edge k. `out_hi_valid` after edge k+1 equals `in_valid` at edge k, so the two flags for one addition are exactly one cycle apart.
- R6: With a new addition presented on every cycle (lower bits at cycle c, upper bits at c+1), each addition gives the full 5-bit value `A + B` as {`out_carry`, `out_sum_hi`, `out_sum_lo`}. `out_sum_lo` is taken one cycle before the other two. The block has no idle cycles.
- R7: A carry made in the lower half reaches the upper half. Cases: 3+1 gives 4, 15+15 gives 30 with `out_carry`=1, and 15+1 gives 16 (upper sum 0, `out_carry`=1).
- R8: `in_valid` has no effect on the sums or on the carry. Operands presented with `in_valid` low still give the sums and carry of R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lo_a | input | 2 | Operand A bits 1:0 for the addition starting this cycle |
| lo_b | input | 2 | Operand B bits 1:0 for the addition starting this cycle |
| in_valid | input | 1 | Marks the lower operand bits as a real addition |
| hi_a | input | 2 | Operand A bits 3:2 of the addition started one cycle earlier |
| hi_b | input | 2 | Operand B bits 3:2 of the addition started one cycle earlier |
| out_sum_lo | output | 2 | Sum bits 1:0, one cycle after the lower operands |
| out_lo_valid | output | 1 | Valid flag for out_sum_lo |
| out_sum_hi | output | 2 | Sum bits 3:2, one cycle after out_sum_lo of the same addition |
| out_carry | output | 1 | Carry out of bit 3, aligned with out_sum_hi |
| out_hi_valid | output | 1 | Valid flag for out_sum_hi and out_carry |

## Verification
- **Lower half:** if an addition's lower bits are driven in cycle c, its lower sum and lower valid are due after the edge that ends cycle c. The bench therefore checks them at the falling edge of cycle c+1, before driving new inputs.
- **Upper half:** the upper sum, carry-out and upper valid of the same addition pass one more register, so they are checked at the falling edge of cycle c+2.
- **Reference model:** the bench computes each expected value from the whole 4-bit operands, not from the halves.
- **Start-up:** right after reset, the upper half is compared against a zero addition, because the carry register has just been cleared.

// File: rtl/sadd_pkg.sv
`timescale 1ns/1ps
package sadd_pkg;
    localparam int HALF_W = 2;
    localparam int FULL_W = 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] sum_lo;
        logic              mid_carry;
        logic              lo_vld;
        logic [HALF_W-1:0] sum_hi;
        logic              cout;
        logic              hi_vld;
    } pipe_t;
endpackage

// File: rtl/sadd_fa_cell.sv
`timescale 1ns/1ps
// One full-adder bit: sum and carry from two operand bits and a carry in.
module sadd_fa_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);
    logic half_x;

    always_comb begin
        half_x = a ^ b;
        s      = half_x ^ ci;
        co     = (a & b) | (half_x & ci);
    end
endmodule

// File: rtl/sadd_ripple_half.sv
`timescale 1ns/1ps
// W-bit ripple-carry chain built from full-adder cells.
module sadd_ripple_half #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         co
);
    logic [W:0] chain;

    assign chain[0] = ci;
    assign co       = chain[W];

    for (genvar i = 0; i < W; i++) begin : g_bit
        sadd_fa_cell i_fa (
            .a  (a[i]),
            .b  (b[i]),
            .ci (chain[i]),
            .s  (sum[i]),
            .co (chain[i+1])
        );
    end
endmodule

// File: rtl/stagger_add4.sv
`timescale 1ns/1ps
// Two-stage adder with skewed operands: the lower half works in cycle c,
// the upper half in cycle c+1, joined by a registered carry.
module stagger_add4
    import sadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] lo_a,
    input  logic [HALF_W-1:0] lo_b,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] hi_a,
    input  logic [HALF_W-1:0] hi_b,
    output logic [HALF_W-1:0] out_sum_lo,
    output logic              out_lo_valid,
    output logic [HALF_W-1:0] out_sum_hi,
    output logic              out_carry,
    output logic              out_hi_valid
);
    pipe_t st_d, st_q;

    logic [HALF_W-1:0] lo_sum_w, hi_sum_w;
    logic              lo_co_w, hi_co_w;

    // Lower half: no carry in.
    sadd_ripple_half #(.W(HALF_W)) i_lo_half (
        .a   (lo_a),
        .b   (lo_b),
        .ci  (1'b0),
        .sum (lo_sum_w),
        .co  (lo_co_w)
    );

    // Upper half: carry in comes from the register loaded one edge earlier.
    sadd_ripple_half #(.W(HALF_W)) i_hi_half (
        .a   (hi_a),
        .b   (hi_b),
        .ci  (st_q.mid_carry),
        .sum (hi_sum_w),
        .co  (hi_co_w)
    );

    always_comb begin
        st_d           = st_q;
        st_d.sum_lo    = lo_sum_w;
        st_d.mid_carry = lo_co_w;
        st_d.lo_vld    = in_valid;
        st_d.sum_hi    = hi_sum_w;
        st_d.cout      = hi_co_w;
        st_d.hi_vld    = st_q.lo_vld;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign out_sum_lo   = st_q.sum_lo;
    assign out_lo_valid = st_q.lo_vld;
    assign out_sum_hi   = st_q.sum_hi;
    assign out_carry    = st_q.cout;
    assign out_hi_valid = st_q.hi_vld;
endmodule

// File: rtl/stagger_add4_chk.sv
`timescale 1ns/1ps
module stagger_add4_chk
    import sadd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [HALF_W-1:0] lo_a,
    input logic [HALF_W-1:0] lo_b,
    input logic              in_valid,
    input logic [HALF_W-1:0] hi_a,
    input logic [HALF_W-1:0] hi_b,
    input logic [HALF_W-1:0] out_sum_lo,
    input logic              out_lo_valid,
    input logic [HALF_W-1:0] out_sum_hi,
    input logic              out_carry,
    input logic              out_hi_valid
);
    logic [HALF_W:0] lo_total;
    logic [1:0]      seen;

    assign lo_total = {1'b0, lo_a} + {1'b0, lo_b};

    always_ff @(posedge clk) begin
        if (rst)
            seen <= 2'd0;
        else if (seen != 2'd3)
            seen <= seen + 2'd1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_sum_lo == '0 && !out_lo_valid && out_sum_hi == '0
                        && !out_carry && !out_hi_valid));

    // R2
    lo_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd1) |-> (out_sum_lo == $past(lo_total[HALF_W-1:0])));

    // R3
    hi_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2) |-> ({out_carry, out_sum_hi} ==
            ({1'b0, $past(hi_a)} + {1'b0, $past(hi_b)}
             + {{HALF_W{1'b0}}, $past(lo_total[HALF_W], 2)})));

    // R5
    lo_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd1) |-> (out_lo_valid == $past(in_valid)));

    // R5
    hi_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (seen >= 2'd2) |-> (out_hi_valid == $past(in_valid, 2)));
endmodule

bind stagger_add4 stagger_add4_chk i_chk (.*);

// File: tb/test_stagger_add4.sv
`timescale 1ns/1ps
module test_stagger_add4;
    localparam int N_DIR = 6;
    localparam int N_RND = 300;
    localparam int N_TOT = N_DIR + N_RND;
    localparam int LAST  = N_TOT + 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lo_a = '0, lo_b = '0, hi_a = '0, hi_b = '0;
    logic       in_valid = 1'b0;
    logic [1:0] out_sum_lo, out_sum_hi;
    logic       out_lo_valid, out_carry, out_hi_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [3:0] op_a [0:LAST];
    logic [3:0] op_b [0:LAST];
    logic       op_v [0:LAST];

    always #2 clk = ~clk;

    stagger_add4 i_stagger_add4 (
        .clk, .rst, .lo_a, .lo_b, .in_valid, .hi_a, .hi_b,
        .out_sum_lo, .out_lo_valid, .out_sum_hi, .out_carry, .out_hi_valid
    );

    function automatic logic [4:0] full_sum(logic [3:0] a, logic [3:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outputs present during cycle c: lower half of op c-1, upper half of op c-2.
    task automatic check_cycle(int c);
        logic [4:0] s;
        string tag;
        s   = full_sum(op_a[c-1], op_b[c-1]);
        tag = (c - 1 <= N_DIR) ? "R7/R2" : (op_v[c-1] ? "R2" : "R8");
        chk(tag, out_sum_lo, s[1:0]);
        chk("R5", out_lo_valid, op_v[c-1]);
        if (c >= 2) begin
            s   = full_sum(op_a[c-2], op_b[c-2]);
            tag = (c - 2 <= N_DIR) ? "R7/R3" : (op_v[c-2] ? "R6/R3" : "R8");
            chk(tag, out_sum_hi, s[3:2]);
            chk((c - 2 <= N_DIR) ? "R7/R4" : "R4", out_carry, s[4]);
            chk("R5", out_hi_valid, op_v[c-2]);
        end
    endtask

    task automatic drive_cycle(int c);
        lo_a     = op_a[c][1:0];
        lo_b     = op_b[c][1:0];
        in_valid = op_v[c];
        hi_a     = op_a[c-1][3:2];
        hi_b     = op_b[c-1][3:2];
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i <= LAST; i++) begin
            op_a[i] = '0; op_b[i] = '0; op_v[i] = 1'b0;
        end
        // R7 directed corner cases
        op_a[1] = 4'd3;  op_b[1] = 4'd1;  op_v[1] = 1'b1;
        op_a[2] = 4'd15; op_b[2] = 4'd15; op_v[2] = 1'b1;
        op_a[3] = 4'd0;  op_b[3] = 4'd0;  op_v[3] = 1'b1;
        op_a[4] = 4'd15; op_b[4] = 4'd1;  op_v[4] = 1'b1;
        op_a[5] = 4'd12; op_b[5] = 4'd4;  op_v[5] = 1'b0;
        op_a[6] = 4'd2;  op_b[6] = 4'd2;  op_v[6] = 1'b1;
        for (int i = N_DIR + 1; i <= N_TOT; i++) begin
            op_a[i] = 4'($urandom_range(0, 15));
            op_b[i] = 4'($urandom_range(0, 15));
            op_v[i] = ($urandom_range(0, 3) != 0);
        end

        // R1: junk inputs during reset
        lo_a = 2'd3; lo_b = 2'd3; hi_a = 2'd3; hi_b = 2'd3; in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", out_sum_lo, 0);
        chk("R1", out_lo_valid, 0);
        chk("R1", out_sum_hi, 0);
        chk("R1", out_carry, 0);
        chk("R1", out_hi_valid, 0);
        rst = 1'b0;
        drive_cycle(1);
        for (int c = 2; c <= LAST; c++) begin
            @(negedge clk);
            check_cycle(c);
            drive_cycle(c);
        end
        @(negedge clk);
        check_cycle(LAST + 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule